// File: doc/BRIEF.md
# Software Write-Protection Command Sequencer

This block sits in front of the page buffer of a nonvolatile memory write controller and watches every write cycle that arrives. It recognises short command sequences written to fixed addresses. One sequence switches a protection flag on, or opens the array for one page load while the flag is on. A longer sequence switches the flag off. For each data write it decides whether the byte may enter the page buffer (`wr_permit`). When the array is protected and the write came without the opening sequence, it asks the controller for a programming period that commits nothing (`dummy_prog`). During that period, reads behave as status polling.

Consecutive command writes must arrive within a byte-load window of the previous write. A write that does not match the next expected step sends the matcher back to idle, and that write is then handled as an ordinary write. The protection flag models a nonvolatile bit. On reset it is reloaded from `nv_prot`, which the surrounding logic keeps in persistent storage. Reset therefore never clears protection. A device that has never been enabled starts unprotected.

Top module: `sdp_seq`

## Requirements
- R1: During and right after reset, `wr_permit` and `dummy_prog` are low, and `prot_on` equals `nv_prot`. With `nv_prot` = 0 (the as-shipped state), protection is off.
- R2: While unprotected and the matcher is idle, a write that is not a command step raises `wr_permit` for exactly one cycle, in the cycle after `wr_evt`. `dummy_prog` stays low. Outputs never pulse without a write in the previous cycle.
- R3: The enable/open sequence is three writes: data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. None of the three is permitted into the page buffer, and none requests a dummy program.
- R4: After the enable sequence completes while unprotected, `prot_on` stays 0 until the byte-load window and then one programming period (`PROG_CYC` cycles) have elapsed, and then becomes 1. A write that arrives during that programming period raises neither output.
- R5: While protected, a write that is not preceded by the opening sequence raises `dummy_prog` for one cycle and does not raise `wr_permit`.
- R6: While protected, writes that follow the opening sequence are each permitted, as long as each falls within the window of the previous write. Once the window lapses, the next plain write gets `dummy_prog` again.
- R7: The disable sequence is six writes: 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, 0x20 to 0x5555. None of the six is permitted or dummied. `prot_on` is 0 in the cycle after the sixth write, and later plain writes are permitted.
- R8: If more than `WIN_CYC` cycles pass between two command writes, the matcher returns to idle, and a later step of the sequence is treated as a plain write.
- R9: A write that does not match the expected step returns the matcher to idle and is handled as a plain write. A following step does not continue the abandoned sequence.
- R10: Reset clears any partly matched sequence but never clears protection: `prot_on` reloads from `nv_prot`.
- R11: `wr_permit` and `dummy_prog` are never high in the same cycle, and `prot_on` falls only on a write or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nv_prot | input | 1 | Persisted protection flag, loaded on reset |
| wr_evt | input | 1 | One-cycle pulse marking a write cycle |
| wr_addr | input | AW | Address of the write |
| wr_data | input | DW | Data byte of the write |
| prot_on | output | 1 | Current protection state |
| wr_permit | output | 1 | Pulse: the previous write may enter the page buffer |
| dummy_prog | output | 1 | Pulse: start a programming period that stores nothing |

## Verification
The matcher is driven with the following patterns:
- Complete enable, open and disable sequences, each against both protection states. These separate withheld command writes from permitted data writes and from dummy-programmed ones.
- Broken sequences: a wrong byte in mid-sequence, and a correct byte that arrives after the window has lapsed. These show that a stale or abandoned prefix is never continued.
- A write made during the arming period, and resets with both values of the persisted flag, including a reset in the middle of a sequence. These separate the timing of protection from the timing of the matcher.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,   // no command in progress
    ST_SEQ,    // part of a command sequence matched
    ST_OPEN,   // open sequence done, page load in progress
    ST_ARM     // programming period before protection takes hold
  } sdp_st_e;

  localparam int unsigned SEQ_STEPS = 6;
  localparam int unsigned STEP_W    = 3;
endpackage

// File: rtl/sdp_cmd_match.sv
module sdp_cmd_match
  import sdp_pkg::*;
#(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] ADDR_A    = 'h5555,
  parameter logic [AW-1:0] ADDR_B    = 'h2AAA,
  parameter logic [DW-1:0] D_LEAD    = 'hAA,
  parameter logic [DW-1:0] D_FOLLOW  = 'h55,
  parameter logic [DW-1:0] D_ENABLE  = 'hA0,
  parameter logic [DW-1:0] D_DISARM  = 'h80,
  parameter logic [DW-1:0] D_DISABLE = 'h20
) (
  input  logic [STEP_W-1:0] step,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     data,
  output logic              adv,
  output logic              ena_hit,
  output logic              dis_hit
);
  function automatic logic [AW-1:0] exp_addr(int i);
    return (i == 1 || i == 4) ? ADDR_B : ADDR_A;
  endfunction

  function automatic logic [DW-1:0] exp_data(int i);
    case (i)
      0, 3:    return D_LEAD;
      1, 4:    return D_FOLLOW;
      2:       return D_DISARM;
      default: return D_DISABLE;
    endcase
  endfunction

  logic [7:0] hit;

  for (genvar g = 0; g < 8; g++) begin : g_step
    if (g < SEQ_STEPS) begin : g_real
      localparam logic [AW-1:0] EA = exp_addr(g);
      localparam logic [DW-1:0] ED = exp_data(g);
      assign hit[g] = (addr == EA) && (data == ED);
    end else begin : g_pad
      assign hit[g] = 1'b0;
    end
  end

  assign adv     = hit[step];
  assign ena_hit = (step == STEP_W'(2)) && (addr == ADDR_A) && (data == D_ENABLE);
  assign dis_hit = (step == STEP_W'(SEQ_STEPS - 1)) && hit[SEQ_STEPS-1];
endmodule

// File: rtl/sdp_timer.sv
module sdp_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == TW'(1));
endmodule

// File: rtl/sdp_seq.sv
module sdp_seq
  import sdp_pkg::*;
#(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] ADDR_A    = 'h5555,
  parameter logic [AW-1:0] ADDR_B    = 'h2AAA,
  parameter logic [DW-1:0] D_LEAD    = 'hAA,
  parameter logic [DW-1:0] D_FOLLOW  = 'h55,
  parameter logic [DW-1:0] D_ENABLE  = 'hA0,
  parameter logic [DW-1:0] D_DISARM  = 'h80,
  parameter logic [DW-1:0] D_DISABLE = 'h20,
  parameter int unsigned WIN_CYC  = 18750,
  parameter int unsigned PROG_CYC = 1250000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nv_prot,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          prot_on,
  output logic          wr_permit,
  output logic          dummy_prog
);
  localparam int unsigned MAXC = (WIN_CYC > PROG_CYC) ? WIN_CYC : PROG_CYC;
  localparam int unsigned TW   = $clog2(MAXC + 1);

  sdp_st_e           st_q, st_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic              prot_q, prot_n;
  logic              perm_q, perm_n;
  logic              dum_q, dum_n;
  logic              adv, ena_hit, dis_hit;
  logic              tmr_load, tmr_done;
  logic [TW-1:0]     tmr_val;

  sdp_cmd_match #(
    .AW(AW), .DW(DW), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B),
    .D_LEAD(D_LEAD), .D_FOLLOW(D_FOLLOW), .D_ENABLE(D_ENABLE),
    .D_DISARM(D_DISARM), .D_DISABLE(D_DISABLE)
  ) u_match (
    .step    (step_q),
    .addr    (wr_addr),
    .data    (wr_data),
    .adv     (adv),
    .ena_hit (ena_hit),
    .dis_hit (dis_hit)
  );

  sdp_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_comb begin
    st_n     = st_q;
    step_n   = step_q;
    prot_n   = prot_q;
    perm_n   = 1'b0;
    dum_n    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = TW'(WIN_CYC);
    if (st_q == ST_ARM) begin
      // writes are dropped while the arming period runs
      if (tmr_done) begin
        prot_n = 1'b1;
        st_n   = ST_IDLE;
      end
    end else if (wr_evt) begin
      if (st_q == ST_OPEN) begin
        perm_n   = 1'b1;
        tmr_load = 1'b1;
      end else if (ena_hit) begin
        st_n     = ST_OPEN;
        step_n   = '0;
        tmr_load = 1'b1;
      end else if (dis_hit) begin
        prot_n = 1'b0;
        st_n   = ST_IDLE;
        step_n = '0;
      end else if (adv) begin
        st_n     = ST_SEQ;
        step_n   = step_q + 1'b1;
        tmr_load = 1'b1;
      end else begin
        st_n   = ST_IDLE;
        step_n = '0;
        if (prot_q) dum_n = 1'b1;
        else        perm_n = 1'b1;
      end
    end else if (tmr_done) begin
      if (st_q == ST_SEQ) begin
        st_n   = ST_IDLE;
        step_n = '0;
      end else if (st_q == ST_OPEN) begin
        if (prot_q) begin
          st_n = ST_IDLE;
        end else begin
          st_n     = ST_ARM;
          tmr_load = 1'b1;
          tmr_val  = TW'(PROG_CYC);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      prot_q <= nv_prot;
      perm_q <= 1'b0;
      dum_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      step_q <= step_n;
      prot_q <= prot_n;
      perm_q <= perm_n;
      dum_q  <= dum_n;
    end
  end

  assign prot_on    = prot_q;
  assign wr_permit  = perm_q;
  assign dummy_prog = dum_q;
endmodule

// File: rtl/sdp_seq_chk.sv
module sdp_seq_chk (
  input logic clk,
  input logic rst,
  input logic wr_evt,
  input logic prot_on,
  input logic wr_permit,
  input logic dummy_prog
);
  AST_EXCL_PULSE: assert property (@(posedge clk) disable iff (rst)
    !(wr_permit && dummy_prog)); // R11

  AST_NO_WRITE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    !wr_evt |=> (!wr_permit && !dummy_prog)); // R2

  AST_DUMMY_ONLY_PROT: assert property (@(posedge clk) disable iff (rst)
    dummy_prog |-> prot_on); // R5

  AST_PROT_RISE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_on) |-> (!wr_permit && !dummy_prog)); // R4

  AST_PROT_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(prot_on) |-> ($past(wr_evt) || $past(rst))); // R11
endmodule

bind sdp_seq sdp_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_evt     (wr_evt),
  .prot_on    (prot_on),
  .wr_permit  (wr_permit),
  .dummy_prog (dummy_prog)
);

// File: tb/sdp_seq_tb.sv
module sdp_seq_tb;
  localparam int WIN  = 40;
  localparam int PROG = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nv_prot = 1'b0;
  logic        wr_evt = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prot_on, wr_permit, dummy_prog;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 0;
  logic  seen;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  sdp_seq #(.WIN_CYC(WIN), .PROG_CYC(PROG)) u_dut (
    .clk(clk), .rst(rst), .nv_prot(nv_prot), .wr_evt(wr_evt),
    .wr_addr(wr_addr), .wr_data(wr_data), .prot_on(prot_on),
    .wr_permit(wr_permit), .dummy_prog(dummy_prog)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // driver: one write, expected {permit, dummy} pushed to the scoreboard
  task automatic wr(logic [14:0] a, logic [7:0] d, logic ep, logic ed, string tag);
    @(negedge clk);
    wr_evt  = 1'b1;
    wr_addr = a;
    wr_data = d;
    exp_q.push_back({ep, ed});
    tag_q.push_back(tag);
    @(negedge clk);
    wr_evt = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic nv);
    @(negedge clk);
    rst = 1'b1;
    nv_prot = nv;
    idle(2);
    rst = 1'b0;
  endtask

  // monitor: compares outputs one cycle after each write event
  always @(posedge clk) begin
    seen = wr_evt;
    #2;
    if (seen && !rst) begin
      logic [1:0] e;
      string t;
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: actual output with no expected item, expected an item");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "wr_permit", wr_permit, e[1]);
        check(t, "dummy_prog", dummy_prog, e[0]);
        check("R11", "exclusive pulses", wr_permit && dummy_prog, 1'b0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset with the as-shipped flag
    do_reset(1'b0);
    check("R1", "prot_on", prot_on, 1'b0);
    check("R1", "wr_permit", wr_permit, 1'b0);
    check("R1", "dummy_prog", dummy_prog, 1'b0);

    // R2: plain write while unprotected
    wr(15'h0100, 8'h11, 1, 0, "R2");
    wr(15'h5555, 8'h55, 1, 0, "R2");

    // R3 / R4: enable sequence, then arming period
    wr(15'h5555, 8'hAA, 0, 0, "R3");
    wr(15'h2AAA, 8'h55, 0, 0, "R3");
    wr(15'h5555, 8'hA0, 0, 0, "R3");
    idle(WIN + 8);
    check("R4", "prot_on before arming ends", prot_on, 1'b0);
    wr(15'h0200, 8'h22, 0, 0, "R4");
    check("R4", "prot_on during arming", prot_on, 1'b0);
    idle(PROG);
    check("R4", "prot_on after arming", prot_on, 1'b1);

    // R5: unprotected-style write now dummied
    wr(15'h0300, 8'h33, 0, 1, "R5");

    // R6: open sequence then a page load
    wr(15'h5555, 8'hAA, 0, 0, "R6");
    wr(15'h2AAA, 8'h55, 0, 0, "R6");
    wr(15'h5555, 8'hA0, 0, 0, "R6");
    wr(15'h0400, 8'h44, 1, 0, "R6");
    idle(WIN - 10);
    wr(15'h0401, 8'h45, 1, 0, "R6");
    idle(WIN + 8);
    wr(15'h0402, 8'h46, 0, 1, "R6");
    check("R6", "prot_on kept", prot_on, 1'b1);

    // R9: wrong byte mid-sequence
    wr(15'h5555, 8'hAA, 0, 0, "R9");
    wr(15'h1234, 8'h00, 0, 1, "R9");
    wr(15'h2AAA, 8'h55, 0, 1, "R9");

    // R8: gap beyond the window
    wr(15'h5555, 8'hAA, 0, 0, "R8");
    idle(WIN + 8);
    wr(15'h2AAA, 8'h55, 0, 1, "R8");
    wr(15'h5555, 8'hA0, 0, 1, "R8");

    // R7: disable sequence
    wr(15'h5555, 8'hAA, 0, 0, "R7");
    wr(15'h2AAA, 8'h55, 0, 0, "R7");
    wr(15'h5555, 8'h80, 0, 0, "R7");
    wr(15'h5555, 8'hAA, 0, 0, "R7");
    wr(15'h2AAA, 8'h55, 0, 0, "R7");
    check("R7", "prot_on before last step", prot_on, 1'b1);
    wr(15'h5555, 8'h20, 0, 0, "R7");
    check("R7", "prot_on after disable", prot_on, 1'b0);
    wr(15'h0500, 8'h55, 1, 0, "R7");

    // R10: reset with persisted flag set, and reset mid-sequence
    do_reset(1'b1);
    check("R10", "prot_on reloaded", prot_on, 1'b1);
    check("R1", "wr_permit after reset", wr_permit, 1'b0);
    wr(15'h0600, 8'h66, 0, 1, "R10");
    wr(15'h5555, 8'hAA, 0, 0, "R10");
    wr(15'h2AAA, 8'h55, 0, 0, "R10");
    do_reset(1'b1);
    wr(15'h5555, 8'hA0, 0, 1, "R10");
    check("R10", "prot_on after mid-sequence reset", prot_on, 1'b1);

    idle(4);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule